// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block is the digital front end of a successive-approximation converter. It holds a small set of registers on a plain write/read bus and decides when a conversion begins. There are three trigger sources: an overflow pulse from a timer, a software write, or a chosen edge on an external start pin. The converter itself sits outside the block. It is reached through a one-cycle start pulse and a done pulse that comes back.

The block also produces a divided clock enable for the converter and keeps a sticky completion flag. The flag, ANDed with an interrupt enable, forms the interrupt. A wake request follows the interrupt, but only while the device is not powered down. Per-channel disable signals cut the digital input path of every pin that is chosen as an analog channel, but only while the converter is enabled.

Register map, with the 2-bit address in brackets:
- [0] control: bits 1:0 start mode, bit 2 enable, bit 3 completion flag, bit 4 edge polarity, bit 5 interrupt enable, bit 6 timer mode, bit 7 reads 0.
- [1] divider ratio: bits 2:0.
- [2] channel select: bits 7:0.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset all three registers read 0 and conv_start_o, conv_tick_o, irq_o, wake_o and din_dis_o are all low.
- R2: With start mode 00 and timer mode bit 6 at 1, each tmr_ovf_i pulse starts a conversion in the same cycle. With bit 6 at 0, mode 00 is stop mode and overflows start nothing.
- R3: A control write that carries mode 01 and enable 1 issues exactly one start pulse, in the cycle after the write. No further start follows until the next such write.
- R4: In mode 10 the start pin passes through a two-stage synchronizer. A falling edge triggers a start when bit 4 is 0, and a rising edge triggers a start when bit 4 is 1. The opposite edge does nothing.
- R5: While enable is 0 or pwr_down_i is 1, no start pulse and no conv_tick_o occur. A start request made in that state is discarded and is not replayed later.
- R6: From a start pulse until conv_done_i, the converter is busy. Overflows, pin edges and pending requests that arrive while busy are dropped. A conv_done_i with no conversion in flight is ignored.
- R7: The completion flag (bit 3) sets when a conversion in flight receives conv_done_i. It clears only on a control write with bit 3 at 0; writing bit 3 as 1 keeps its value. If a hardware set and a software clear fall in the same cycle, the set wins.
- R8: irq_o is the completion flag AND the interrupt enable (bit 5). wake_o equals irq_o while pwr_down_i is 0 and is low while pwr_down_i is 1.
- R9: With divider value r, conv_tick_o pulses once every r+1 cycles, giving ratios 1 to 8. Writing the divider restarts the count, so the first tick comes r+1 cycles after the write.
- R10: din_dis_o[c] is high exactly when channel-select bit c is 1 and enable is 1.
- R11: Registers read back what was written, except that control bit 7 reads 0 and bit 3 follows R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_start_i | input | 1 | Asynchronous external start pin |
| pwr_down_i | input | 1 | Device in power-down |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_tick_o | output | 1 | Divided converter clock enable |
| irq_o | output | 1 | Completion interrupt |
| wake_o | output | 1 | Wake request from idle |
| din_dis_o | output | 8 | Per-channel digital input disable |

## Verification
The completion set and the software clear of the flag can land on the same edge. The bench provokes this by raising conv_done_i during a conversion in the same cycle as a control write that carries bit 3 at 0. It then expects the flag to read 1 and irq_o to stay high, and it expects a second, undisturbed write to clear the flag. The same kind of overlap is exercised for triggers: timer overflows and pin edges that arrive while a conversion is busy must not raise the start count.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_IMM   = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_RSVD  = 2'b11
  } start_mode_e;

  typedef struct packed {
    logic        tmode;
    logic        ie;
    logic        pol;
    logic        flag;
    logic        en;
    start_mode_e mode;
  } ctrl_t;

  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CHSEL = 2'd2;
  localparam int unsigned FLAG_BIT = 3;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               restart_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic               wrap;

  assign wrap = (cnt_q == ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (wrap)               cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i & wrap;
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_start_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  start_mode_e mode_i,
  input  logic        tmode_i,
  input  logic        pol_i,
  input  logic        tmr_ovf_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        imm_req_i,
  input  logic        done_i,
  output logic        start_o,
  output logic        finish_o,
  output logic        busy_o
);
  logic busy_q, pend_q, trig;

  always_comb begin
    case (mode_i)
      MODE_TIMER: trig = tmode_i & tmr_ovf_i;
      MODE_IMM:   trig = pend_q;
      MODE_EDGE:  trig = pol_i ? rise_i : fall_i;
      default:    trig = 1'b0;
    endcase
  end

  assign start_o  = run_i & ~busy_q & trig;
  assign finish_o = busy_q & done_i;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // a fresh write wins over any cancel condition
      if (imm_req_i)                                   pend_q <= 1'b1;
      else if (start_o || busy_q || !run_i || mode_i != MODE_IMM) pend_q <= 1'b0;

      if (!run_i)       busy_q <= 1'b0;
      else if (start_o) busy_q <= 1'b1;
      else if (done_i)  busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
  import adc_start_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tmr_ovf_i,
  input  logic              ext_start_i,
  input  logic              pwr_down_i,
  input  logic              conv_done_i,
  output logic              conv_start_o,
  output logic              conv_tick_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic [NUM_CH-1:0] din_dis_o
);
  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_CH-1:0] chsel_q;
  logic wr_ctrl, wr_div, wr_chsel, imm_req, run;
  logic rise, fall, finish, seq_busy;

  assign wr_ctrl  = reg_we_i && reg_addr_i == A_CTRL;
  assign wr_div   = reg_we_i && reg_addr_i == A_DIV;
  assign wr_chsel = reg_we_i && reg_addr_i == A_CHSEL;
  assign imm_req  = wr_ctrl && reg_wdata_i[1:0] == MODE_IMM && reg_wdata_i[2];
  assign run      = ctrl_q.en & ~pwr_down_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      chsel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.mode  <= start_mode_e'(reg_wdata_i[1:0]);
        ctrl_q.en    <= reg_wdata_i[2];
        ctrl_q.pol   <= reg_wdata_i[4];
        ctrl_q.ie    <= reg_wdata_i[5];
        ctrl_q.tmode <= reg_wdata_i[6];
      end
      // hardware set beats software clear; software can only clear
      if (finish)                               ctrl_q.flag <= 1'b1;
      else if (wr_ctrl && !reg_wdata_i[FLAG_BIT]) ctrl_q.flag <= 1'b0;
      if (wr_div)   div_q   <= reg_wdata_i[DIV_W-1:0];
      if (wr_chsel) chsel_q <= reg_wdata_i[NUM_CH-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o[6:0]        = ctrl_q;
      A_DIV:   reg_rdata_o[DIV_W-1:0]  = div_q;
      A_CHSEL: reg_rdata_o[NUM_CH-1:0] = chsel_q;
      default: reg_rdata_o = '0;
    endcase
  end

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_start_i),
    .rise_o(rise), .fall_o(fall)
  );

  adc_start_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .mode_i(ctrl_q.mode), .tmode_i(ctrl_q.tmode), .pol_i(ctrl_q.pol),
    .tmr_ovf_i(tmr_ovf_i), .rise_i(rise), .fall_i(fall),
    .imm_req_i(imm_req), .done_i(conv_done_i),
    .start_o(conv_start_o), .finish_o(finish), .busy_o(seq_busy)
  );

  adc_clk_div #(.RATIO_W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .restart_i(wr_div),
    .ratio_i(div_q), .tick_o(conv_tick_o)
  );

  assign irq_o  = ctrl_q.flag & ctrl_q.ie;
  assign wake_o = irq_o & ~pwr_down_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_din
    assign din_dis_o[c] = chsel_q[c] & ctrl_q.en;
  end
endmodule

// File: rtl/adc_start_ctrl_sva.sv
module adc_start_ctrl_sva
  import adc_start_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              pwr_down_i,
  input logic              conv_done_i,
  input logic              conv_start_o,
  input logic              conv_tick_o,
  input logic              irq_o,
  input logic              wake_o,
  input logic [NUM_CH-1:0] din_dis_o,
  input logic              en_i,
  input logic              ie_i,
  input logic              flag_i,
  input logic              busy_i
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && reg_addr_i == A_CTRL;

  assert_start_powered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (en_i && !pwr_down_i));
  assert_tick_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || pwr_down_i) |-> !conv_tick_o);
  assert_single_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && conv_done_i) |=> flag_i);
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !ctrl_wr) |=> flag_i);
  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !irq_o);
  assert_no_wake_pd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> !wake_o);
  assert_din_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (din_dis_o == '0));
endmodule

bind adc_start_ctrl adc_start_ctrl_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .pwr_down_i(pwr_down_i), .conv_done_i(conv_done_i), .conv_start_o(conv_start_o),
  .conv_tick_o(conv_tick_o), .irq_o(irq_o), .wake_o(wake_o), .din_dis_o(din_dis_o),
  .en_i(ctrl_q.en), .ie_i(ctrl_q.ie), .flag_i(ctrl_q.flag), .busy_i(seq_busy)
);

// File: tb/adc_start_ctrl_test.sv
module adc_start_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ovf = 1'b0, pin = 1'b0, pd = 1'b0, done = 1'b0;
  logic       start, tick, irq, wake;
  logic [7:0] din;
  int checks = 0, errors = 0;
  int starts = 0, ticks = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  adc_start_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tmr_ovf_i(ovf),
    .ext_start_i(pin), .pwr_down_i(pd), .conv_done_i(done),
    .conv_start_o(start), .conv_tick_o(tick), .irq_o(irq), .wake_o(wake),
    .din_dis_o(din)
  );

  always @(posedge clk_i) begin
    if (start) starts <= starts + 1;
    if (tick)  ticks  <= ticks + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); we = 1'b1; addr = a; wdata = d;
    @(negedge clk_i); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_ovf;
    @(negedge clk_i); ovf = 1'b1; @(negedge clk_i); ovf = 1'b0;
  endtask

  task automatic pulse_done;
    @(negedge clk_i); done = 1'b1; @(negedge clk_i); done = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 start", start, 0); chk("R1 tick", tick, 0);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0); chk("R1 din", din, 0);
  endtask

  task automatic t_timer;
    int b; logic [7:0] v;
    wr(0, 8'h44); b = starts;
    pulse_ovf(); idle(1);
    chk("R2 timer start", starts - b, 1);
    pulse_ovf(); idle(1);
    chk("R6 overflow while busy", starts - b, 1);
    pulse_done(); rd(0, v);
    chk("R7 flag set", v[3], 1);
    pulse_ovf(); idle(1);
    chk("R2 second overflow", starts - b, 2);
    pulse_done();
    wr(0, 8'h04); rd(0, v);
    chk("R7 flag cleared", v[3], 0);
    pulse_ovf(); idle(2);
    chk("R2 stop mode", starts - b, 2);
  endtask

  task automatic t_imm;
    int b;
    b = starts;
    wr(0, 8'h05); idle(2);
    chk("R3 immediate start", starts - b, 1);
    idle(6);
    chk("R3 single start", starts - b, 1);
    pulse_done(); idle(3);
    chk("R3 idle after done", starts - b, 1);
    pulse_done(); idle(2);
    chk("R6 stray done ignored", starts - b, 1);
    wr(0, 8'h05); idle(2);
    chk("R3 rewrite starts", starts - b, 2);
    pulse_done();
  endtask

  task automatic t_edge;
    int b;
    b = starts;
    wr(0, 8'h06);
    @(negedge clk_i); pin = 1'b1; idle(4);
    chk("R4 rising ignored pol0", starts - b, 0);
    @(negedge clk_i); pin = 1'b0; idle(4);
    chk("R4 falling pol0", starts - b, 1);
    pulse_done();
    wr(0, 8'h16);
    @(negedge clk_i); pin = 1'b1; idle(4);
    chk("R4 rising pol1", starts - b, 2);
    @(negedge clk_i); pin = 1'b0; idle(4);
    @(negedge clk_i); pin = 1'b1; idle(4);
    chk("R6 edge while busy", starts - b, 2);
    pulse_done(); idle(4);
    chk("R6 edge not replayed", starts - b, 2);
  endtask

  task automatic t_power;
    int b, tb;
    b = starts;
    wr(0, 8'h01); idle(3);
    chk("R5 disabled no start", starts - b, 0);
    @(negedge clk_i); pd = 1'b1;
    wr(0, 8'h05); tb = ticks; idle(6);
    chk("R5 pd no start", starts - b, 0);
    chk("R5 pd no tick", ticks - tb, 0);
    @(negedge clk_i); pd = 1'b0; idle(4);
    chk("R5 request discarded", starts - b, 0);
    wr(0, 8'h00); tb = ticks; idle(8);
    chk("R5 disabled no tick", ticks - tb, 0);
  endtask

  task automatic t_div;
    int tb;
    wr(0, 8'h04);
    for (int r = 0; r < 8; r += 3) begin
      wr(1, 8'(r)); tb = ticks;
      idle(r);
      chk("R9 first tick delay", ticks - tb, 0);
      idle((r + 1) * 4 - r);
      chk("R9 tick rate", ticks - tb, 4);
    end
    wr(1, 8'd7); tb = ticks; idle(4);
    wr(1, 8'd7); idle(7);
    chk("R9 restart on write", ticks - tb, 0);
    idle(1);
    chk("R9 tick after restart", ticks - tb, 1);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(0, 8'h25); idle(2); pulse_done();
    chk("R8 irq", irq, 1); chk("R8 wake", wake, 1);
    @(negedge clk_i); pd = 1'b1; #1;
    chk("R8 irq in pd", irq, 1); chk("R8 no wake in pd", wake, 0);
    @(negedge clk_i); pd = 1'b0;
    wr(0, 8'h0C); rd(0, v);
    chk("R8 irq masked", irq, 0); chk("R7 write 1 keeps flag", v[3], 1);
    wr(0, 8'h2C);
    chk("R8 irq unmasked", irq, 1);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(0, 8'h25); idle(2);
    chk("R7 flag cleared by write", irq, 0);
    @(negedge clk_i); we = 1'b1; addr = 2'd0; wdata = 8'h24; done = 1'b1;
    @(negedge clk_i); we = 1'b0; done = 1'b0;
    rd(0, v);
    chk("R7 set beats clear", v[3], 1);
    chk("R8 irq after collision", irq, 1);
    wr(0, 8'h24); rd(0, v);
    chk("R7 later clear", v[3], 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2, 8'hA5); wr(0, 8'h00);
    chk("R10 din off when disabled", din, 0);
    wr(0, 8'h04);
    chk("R10 din follows select", din, 8'hA5);
    rd(2, v); chk("R11 chsel", v, 8'hA5);
    wr(1, 8'h05); rd(1, v); chk("R11 div", v, 5);
    wr(0, 8'hF4); rd(0, v); chk("R11 ctrl", v, 8'h74);
    wr(0, 8'h00);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    idle(3); rst_ni = 1'b1; idle(1);
    t_reset();
    t_timer();
    t_imm();
    t_edge();
    t_power();
    t_div();
    t_irq();
    t_collide();
    t_regs();
    idle(2);
    summary();
  end
endmodule